// File: doc/BRIEF.md
# Segmented Address Decoder with RAM Isolation

This block turns a 32-bit processor address into a region select. Each region is one of main RAM, boot ROM, the peripheral register page or the bus-control register. Decoding works on 64 KiB pages, which are the upper 16 address bits. The top three address bits choose a segment, and three segment codes (`000`, `100`, `101`) give the same view of RAM and ROM. Every mirror of RAM lands on the same physical word, because the RAM offset is the address taken modulo the physical RAM size.

The decode path is purely combinational. Reads that hit no region return zero on `rd_data`, and writes that hit no region raise no select and no write enable. The one piece of state is an isolation flag. It is updated by a word write to the bus-control address. While the flag is set, word writes into page `0x0000` are dropped, so software can probe memory without corrupting it. When the flag is clear, those writes pass to RAM with address bit 31 forced high on `ram_fwd_addr`.

Top module: `seg_addr_decoder`

## Requirements
- R1: At most one of `sel_ram`, `sel_rom`, `sel_io`, `sel_ctl` is high. All of them are low while `req_valid` is low.
- R2: `sel_ram` is high when `addr[31:29]` is `000`, `100` or `101` and `addr[28:23]` is zero. `ram_offset` equals `addr[20:0]`, and `ram_we` is high exactly when `sel_ram` is high on a write.
- R3: A read with `addr[31:29]` in {`000`,`100`,`101`} and `addr[28:19]` equal to `0x3F8` raises `sel_rom`, with `rom_offset = addr[18:0]`. A write to that range raises no select.
- R4: `addr[31:16] == 0x1F80` raises `sel_io` for every size (`size` 0 = byte, 1 = halfword, 2 = word) and for both read and write. `io_offset` equals `addr[15:0]`.
- R5: A valid read that raises `sel_ram`, `sel_rom` or `sel_io` returns `bus_rdata` on `rd_data`. Any other read returns zero.
- R6: A write that hits no region raises no select and leaves `ram_we` low.
- R7: A valid word write to `0xFFFE0130` raises `sel_ctl`. With data `0x800` or `0x804` it sets `iso_active` on the next clock edge, and with `0x0` or `0x1E988` it clears it. Any other data, size, address or a read leaves `iso_active` unchanged.
- R8: `iso_active` is low after reset.
- R9: While `iso_active` is high, a word write with `addr[31:16] == 0x0000` raises no select and no `ram_we`. Byte and halfword writes, and writes to other RAM pages, still reach RAM.
- R10: `ram_fwd_addr` equals `addr` with bit 31 set for a word write in page `0x0000`, and equals `addr` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word |
| addr | input | 32 | Processor address |
| wdata | input | 32 | Write data |
| bus_rdata | input | 32 | Read data returned by the selected region |
| sel_ram | output | 1 | Main RAM select |
| sel_rom | output | 1 | Boot ROM select (reads only) |
| sel_io | output | 1 | Peripheral page select |
| sel_ctl | output | 1 | Bus-control register select |
| ram_we | output | 1 | RAM write enable |
| ram_offset | output | 21 | Physical RAM byte offset |
| rom_offset | output | 19 | ROM byte offset |
| io_offset | output | 16 | Offset within the peripheral page |
| ram_fwd_addr | output | 32 | Address forwarded toward RAM |
| rd_data | output | 32 | Read data, zero when unmapped |
| iso_active | output | 1 | RAM isolation flag |

## Verification
Selects, offsets, `ram_we`, `ram_fwd_addr` and `rd_data` depend only on the current inputs. The bench therefore checks them one time step after it drives the inputs, in the same cycle. `iso_active` changes only on the clock edge that follows a control write. For that reason each control write is driven on a falling edge and its effect is read at the next falling edge, one edge after capture. The address sweep runs once with isolation clear and once with it set. It does not cross the control address, so the flag stays fixed during each sweep.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic ram;
      logic rom;
      logic io;
      logic ctl;
   } region_sel_t;
endpackage

// File: rtl/seg_region_match.sv
module seg_region_match #(
   parameter int PAGE_W        = 16,
   parameter int SEG_BITS      = 3,
   parameter int NUM_SEGS      = 3,
   parameter logic [NUM_SEGS*SEG_BITS-1:0] SEG_CODES = {3'b101, 3'b100, 3'b000},
   parameter int RAM_WIN_PAGES = 128,
   parameter int ROM_BASE      = 'h1FC0,
   parameter int ROM_PAGES     = 8,
   parameter int IO_PAGE       = 'h1F80,
   localparam int LOW_W        = PAGE_W - SEG_BITS
) (
   input  logic [PAGE_W-1:0] page,
   output logic              ram_hit,
   output logic              rom_hit,
   output logic              io_hit
);
   logic [NUM_SEGS-1:0] seg_hit;
   logic [LOW_W-1:0]    low;
   logic                any_seg;

   if (RAM_WIN_PAGES + 0 > (1 << LOW_W)) begin : g_bad_win
      $error("RAM window larger than a segment");
   end
   if (ROM_BASE + ROM_PAGES > (1 << LOW_W)) begin : g_bad_rom
      $error("ROM range leaves the segment");
   end
   if (ROM_BASE < RAM_WIN_PAGES) begin : g_bad_overlap
      $error("ROM range overlaps RAM window");
   end

   assign low = page[LOW_W-1:0];

   for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
      assign seg_hit[s] = (page[PAGE_W-1 -: SEG_BITS] == SEG_CODES[s*SEG_BITS +: SEG_BITS]);
   end

   assign any_seg = |seg_hit;
   assign ram_hit = any_seg && (low < LOW_W'(RAM_WIN_PAGES));
   assign rom_hit = any_seg && (low >= LOW_W'(ROM_BASE)) && (low < LOW_W'(ROM_BASE + ROM_PAGES));
   assign io_hit  = (page == PAGE_W'(IO_PAGE));
endmodule

// File: rtl/iso_flag_reg.sv
module iso_flag_reg #(
   parameter int          DATA_W = 32,
   parameter logic [31:0] SET_A  = 32'h0000_0800,
   parameter logic [31:0] SET_B  = 32'h0000_0804,
   parameter logic [31:0] CLR_A  = 32'h0000_0000,
   parameter logic [31:0] CLR_B  = 32'h0001_E988
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              iso
);
   logic set_val, clr_val;

   if (DATA_W < 17) begin : g_bad_w
      $error("data width too small for control codes");
   end

   assign set_val = (wdata == DATA_W'(SET_A)) || (wdata == DATA_W'(SET_B));
   assign clr_val = (wdata == DATA_W'(CLR_A)) || (wdata == DATA_W'(CLR_B));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  iso <= 1'b0;
      else if (ctl_wr && set_val)  iso <= 1'b1;
      else if (ctl_wr && clr_val)  iso <= 1'b0;
   end

   AST_ISO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ((wdata == DATA_W'(SET_A)) || (wdata == DATA_W'(SET_B))) |=> iso); // R7
   AST_ISO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ((wdata == DATA_W'(CLR_A)) || (wdata == DATA_W'(CLR_B))) |=> !iso); // R7
   AST_ISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(iso)); // R7
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
   import segdec_pkg::*;
#(
   parameter int          ADDR_W        = 32,
   parameter int          PAGE_W        = 16,
   parameter int          RAM_PAGES     = 32,
   parameter int          RAM_WIN_PAGES = 128,
   parameter int          ROM_BASE      = 'h1FC0,
   parameter int          ROM_PAGES     = 8,
   parameter int          IO_PAGE       = 'h1F80,
   parameter logic [31:0] CTL_ADDR      = 32'hFFFE_0130,
   localparam int PG_OFS_W  = ADDR_W - PAGE_W,
   localparam int RAM_OFS_W = $clog2(RAM_PAGES) + PG_OFS_W,
   localparam int ROM_OFS_W = $clog2(ROM_PAGES) + PG_OFS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [1:0]           size,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   input  logic [31:0]          bus_rdata,
   output logic                 sel_ram,
   output logic                 sel_rom,
   output logic                 sel_io,
   output logic                 sel_ctl,
   output logic                 ram_we,
   output logic [RAM_OFS_W-1:0] ram_offset,
   output logic [ROM_OFS_W-1:0] rom_offset,
   output logic [PG_OFS_W-1:0]  io_offset,
   output logic [ADDR_W-1:0]    ram_fwd_addr,
   output logic [31:0]          rd_data,
   output logic                 iso_active
);
   if (ADDR_W != 32) begin : g_bad_aw
      $error("address width must be 32");
   end
   if ((RAM_PAGES & (RAM_PAGES - 1)) != 0 || RAM_PAGES > RAM_WIN_PAGES) begin : g_bad_ram
      $error("RAM pages must be a power of two within the window");
   end
   if ((ROM_PAGES & (ROM_PAGES - 1)) != 0) begin : g_bad_rompg
      $error("ROM pages must be a power of two");
   end

   logic [PAGE_W-1:0] page;
   logic              ram_hit, rom_hit, io_hit;
   logic              is_word_wr, low_page, iso_drop, ctl_wr;
   region_sel_t       sel;

   assign page = addr[ADDR_W-1 -: PAGE_W];

   seg_region_match #(
      .PAGE_W       (PAGE_W),
      .SEG_BITS     (3),
      .NUM_SEGS     (3),
      .SEG_CODES    ({3'b101, 3'b100, 3'b000}),
      .RAM_WIN_PAGES(RAM_WIN_PAGES),
      .ROM_BASE     (ROM_BASE),
      .ROM_PAGES    (ROM_PAGES),
      .IO_PAGE      (IO_PAGE)
   ) u_match (
      .page   (page),
      .ram_hit(ram_hit),
      .rom_hit(rom_hit),
      .io_hit (io_hit)
   );

   assign is_word_wr = req_valid && req_write && (acc_size_e'(size) == SZ_WORD);
   assign low_page   = (page == '0);
   assign ctl_wr     = is_word_wr && (addr == CTL_ADDR);

   iso_flag_reg #(.DATA_W(32)) u_iso (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl_wr(ctl_wr),
      .wdata (wdata),
      .iso   (iso_active)
   );

   assign iso_drop = is_word_wr && low_page && iso_active;

   always_comb begin
      sel     = '0;
      sel.ram = req_valid && ram_hit && !iso_drop;
      sel.rom = req_valid && rom_hit && !req_write;
      sel.io  = req_valid && io_hit;
      sel.ctl = ctl_wr;
   end

   assign sel_ram      = sel.ram;
   assign sel_rom      = sel.rom;
   assign sel_io       = sel.io;
   assign sel_ctl      = sel.ctl;
   assign ram_we       = sel.ram && req_write;
   assign ram_offset   = addr[RAM_OFS_W-1:0];
   assign rom_offset   = addr[ROM_OFS_W-1:0];
   assign io_offset    = addr[PG_OFS_W-1:0];
   assign ram_fwd_addr = (req_write && (acc_size_e'(size) == SZ_WORD) && low_page)
                         ? {1'b1, addr[ADDR_W-2:0]} : addr;
   assign rd_data      = (req_valid && !req_write && (sel.ram || sel.rom || sel.io))
                         ? bus_rdata : 32'h0;

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_ram, sel_rom, sel_io, sel_ctl})); // R1
   AST_IDLE_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(sel_ram || sel_rom || sel_io || sel_ctl)); // R1
   AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      req_write |-> !sel_rom); // R3
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_ram || sel_rom || sel_io) |-> rd_data == 32'h0); // R5
   AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> sel_ram && req_write); // R6
   AST_ISO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      iso_active && req_valid && req_write && size == 2'd2 && addr[31:16] == 16'h0
      |-> !ram_we && !sel_ram); // R9
endmodule

// File: tb/test_seg_addr_decoder.sv
module test_seg_addr_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  size = 2'd0;
   logic [31:0] addr = 32'h0, wdata = 32'h0;
   logic [31:0] bus_rdata = 32'hA5A5_5A5A;
   logic        sel_ram, sel_rom, sel_io, sel_ctl, ram_we, iso_active;
   logic [20:0] ram_offset;
   logic [18:0] rom_offset;
   logic [15:0] io_offset;
   logic [31:0] ram_fwd_addr, rd_data;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   seg_addr_decoder i_seg_addr_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .size(size), .addr(addr), .wdata(wdata), .bus_rdata(bus_rdata),
      .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_io(sel_io), .sel_ctl(sel_ctl),
      .ram_we(ram_we), .ram_offset(ram_offset), .rom_offset(rom_offset),
      .io_offset(io_offset), .ram_fwd_addr(ram_fwd_addr), .rd_data(rd_data),
      .iso_active(iso_active)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h sz=%0d wr=%0d act=%h exp=%h", req, addr, size, req_write, act, exp);
      end
   endtask

   task automatic sweep_point(input bit iso);
      bit segok, e_ram, e_rom, e_io, drop, e_ctl;
      logic [31:0] e_rd, e_fwd;
      string req;
      segok = (addr[31:29] == 3'b000) || (addr[31:29] == 3'b100) || (addr[31:29] == 3'b101);
      drop  = iso && req_write && size == 2'd2 && addr[31:16] == 16'h0;     // R9
      e_ram = segok && addr[28:23] == 6'h0 && !drop;                         // R2
      e_rom = segok && addr[28:19] == 10'h3F8 && !req_write;                 // R3
      e_io  = addr[31:16] == 16'h1F80;                                       // R4
      e_ctl = req_write && size == 2'd2 && addr == 32'hFFFE_0130;            // R7
      e_rd  = (!req_write && (e_ram || e_rom || e_io)) ? bus_rdata : 32'h0;  // R5
      e_fwd = (req_write && size == 2'd2 && addr[31:16] == 16'h0) ? (addr | 32'h8000_0000) : addr; // R10
      if (e_io) req = "R4";
      else if (e_rom) req = "R3";
      else if (drop) req = "R9";
      else if (e_ram) req = "R2";
      else if (req_write) req = "R6";
      else req = "R5";
      check(req,
         {4'(sel_ram), 4'(sel_rom), 4'(sel_io), 4'(sel_ctl), 4'(ram_we),
          11'h0, ram_offset, 13'h0, rom_offset, rd_data},
         {4'(e_ram), 4'(e_rom), 4'(e_io), 4'(e_ctl), 4'(e_ram && req_write),
          11'h0, addr[20:0], 13'h0, addr[18:0], e_rd});
      check("R10", {96'h0, ram_fwd_addr}, {96'h0, e_fwd});
      if (e_io) check("R4", {112'h0, io_offset}, {112'h0, addr[15:0]});
      check("R1", {127'h0, ($countones({sel_ram, sel_rom, sel_io, sel_ctl}) <= 1)}, {127'h0, 1'b1});
   endtask

   task automatic sweep(input bit iso);
      logic [12:0] pages [14] = '{13'h0000, 13'h0001, 13'h001F, 13'h0020, 13'h007F, 13'h0080,
                                  13'h1F80, 13'h1FBF, 13'h1FC0, 13'h1FC5, 13'h1FC7, 13'h1FC8,
                                  13'h1FFE, 13'h0400};
      for (int s = 0; s < 8; s++)
         for (int p = 0; p < 14; p++)
            for (int z = 0; z < 3; z++)
               for (int w = 0; w < 2; w++) begin
                  req_valid = 1'b1;
                  req_write = w[0];
                  size      = 2'(z);
                  addr      = {3'(s), pages[p], 16'h0134 + 16'(p * 4 + z)};
                  wdata     = 32'h0000_0800;
                  #1;
                  sweep_point(iso);
               end
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic ctl_access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                             input logic [31:0] d, input bit exp_iso, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; size = sz; addr = a; wdata = d;
      #1;
      check("R7", {127'h0, sel_ctl}, {127'h0, (wr && sz == 2'd2 && a == 32'hFFFE_0130)});
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      #1;
      check(req, {127'h0, iso_active}, {127'h0, exp_iso});
   endtask

   initial begin
      #2000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #3;
      check("R8", {127'h0, iso_active}, {127'h0, 1'b0});
      check("R1", {124'h0, sel_ram, sel_rom, sel_io, sel_ctl}, 128'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", {127'h0, iso_active}, {127'h0, 1'b0});
      sweep(1'b0);
      ctl_access(32'hFFFE_0130, 2'd2, 1'b1, 32'h0000_0123, 1'b0, "R7");
      ctl_access(32'hFFFE_0130, 2'd1, 1'b1, 32'h0000_0800, 1'b0, "R7");
      ctl_access(32'hFFFE_0130, 2'd2, 1'b0, 32'h0000_0800, 1'b0, "R7");
      ctl_access(32'hFFFE_0134, 2'd2, 1'b1, 32'h0000_0800, 1'b0, "R7");
      ctl_access(32'hFFFE_0130, 2'd2, 1'b1, 32'h0000_0800, 1'b1, "R7");
      ctl_access(32'hFFFE_0130, 2'd2, 1'b1, 32'h0000_0123, 1'b1, "R7");
      ctl_access(32'hFFFE_0130, 2'd2, 1'b1, 32'h0000_0000, 1'b0, "R7");
      ctl_access(32'hFFFE_0130, 2'd2, 1'b1, 32'h0000_0804, 1'b1, "R7");
      ctl_access(32'hFFFE_0130, 2'd2, 1'b0, 32'h0000_0000, 1'b1, "R7");
      @(negedge clk);
      sweep(1'b1);
      ctl_access(32'hFFFE_0130, 2'd2, 1'b1, 32'h0001_E988, 1'b0, "R7");
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; size = 2'd2; addr = 32'h0000_0010; #1;
      check("R10", {96'h0, ram_fwd_addr}, {96'h0, 32'h8000_0010});
      check("R9", {127'h0, ram_we}, {127'h0, 1'b1});
      req_valid = 1'b0; req_write = 1'b0;
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule